// File: doc/BRIEF.md
# Reservation Station Bank with Broadcast Wakeup

This block is the scheduling window for an out-of-order core. Each renamed micro-operation is written into a free station with its opcode, its destination physical tag and two source operands. A source either arrives with its value, read from the physical register file when the operation is inserted, or arrives as a physical tag only. A tag-only source waits until a result carrying that tag is broadcast.

Each cycle the bank picks one station whose two operands are both present. It sends that station to a single-cycle ALU, which supports add, subtract, multiply (low half) and exclusive-or on 32-bit data. In the next cycle the result and its destination tag go out on the broadcast bus. Every station waiting on that tag captures the value from the bus, so a dependent operation becomes ready without a second register file read. One broadcast can wake several stations at once.

Top module: `rsv_wakeup_bank`

## Requirements
- R1: A new operation is written into the lowest-numbered free station. `insReady` is low while all four stations are occupied. An insert offered while `insReady` is low is dropped and never produces a broadcast.
- R2: A station issues only once both of its operands hold values. A station that waits on a tag which is never broadcast never issues.
- R3: At most one station issues per cycle. When several are ready, the lowest-numbered one goes first and the others follow in later cycles.
- R4: The cycle after a station issues, `bcValid` is high, `bcTag` carries its destination tag and `bcData` carries the result. The `insOp` encoding is 0 add, 1 subtract (A minus B), 2 multiply keeping the low 32 bits, 3 exclusive-or. An operation inserted with both operands present broadcasts two cycles after its insert cycle.
- R5: A broadcast fills every waiting operand in every station whose tag matches. Woken stations can issue in the cycle after the broadcast, so their results appear two or more cycles after the waking broadcast.
- R6: If an operation is inserted in the same cycle as a broadcast of one of its source tags, it captures that value as present.
- R7: A station is freed when its result is broadcast. In that broadcast cycle, `insReady` is already high again for the freed station, and that station can be reused.
- R8: After reset, no station is occupied, `insReady` is high and `bcValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| insValid | input | 1 | Offer of a new operation |
| insReady | output | 1 | A station is free to take the offer |
| insOp | input | 2 | ALU operation code |
| insDst | input | 6 | Destination physical tag |
| insAAvail | input | 1 | Source A value is present on insAData |
| insATag | input | 6 | Source A tag when not present |
| insAData | input | 32 | Source A value |
| insBAvail | input | 1 | Source B value is present on insBData |
| insBTag | input | 6 | Source B tag when not present |
| insBData | input | 32 | Source B value |
| bcValid | output | 1 | Result broadcast valid |
| bcTag | output | 6 | Tag of the broadcast result |
| bcData | output | 32 | Broadcast result value |

## Verification
The assertions take for granted that each destination tag has at most one producer in flight, so a broadcast wakes only the operands meant for it. They also assume that the only broadcasts are the bank's own ALU results. The stimulus gives each operation in a test its own destination tag. It resets the bank between tests, which clears stations left waiting on tags that are never produced on purpose, so no tag is reused while a station still waits on it.

// File: rtl/rsv_pkg.sv
`timescale 1ns/1ps
package rsv_pkg;
  parameter int RS_COUNT = 4;
  parameter int DATA_W   = 32;
  parameter int TAG_W    = 6;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_MUL = 2'd2,
    OP_XOR = 2'd3
  } aluOp_e;

  // Strobes from the control side to the datapath side
  typedef struct packed {
    logic [RS_COUNT-1:0] insWr;   // station written by the insert port
    logic [RS_COUNT-1:0] issue;   // station sent to the ALU this cycle
    logic [RS_COUNT-1:0] capA;    // station captures broadcast into A
    logic [RS_COUNT-1:0] capB;    // station captures broadcast into B
    logic                insCapA; // inserted A taken from the broadcast
    logic                insCapB; // inserted B taken from the broadcast
    logic                issueFire;
  } rsStrobe_t;
endpackage

// File: rtl/rsv_ctrl.sv
`timescale 1ns/1ps
module rsv_ctrl import rsv_pkg::*; (
  input  logic             clk,
  input  logic             rstN,
  input  logic             insValid,
  output logic             insReady,
  input  logic             insAAvail,
  input  logic [TAG_W-1:0] insATag,
  input  logic             insBAvail,
  input  logic [TAG_W-1:0] insBTag,
  input  logic             bcValid,
  input  logic [TAG_W-1:0] bcTag,
  output rsStrobe_t        strb
);
  localparam logic [RS_COUNT-1:0] LSB_ONE = RS_COUNT'(1);

  logic [RS_COUNT-1:0] slotValid, aAvail, bAvail;
  logic [TAG_W-1:0]    aTag [RS_COUNT];
  logic [TAG_W-1:0]    bTag [RS_COUNT];
  logic [RS_COUNT-1:0] readyVec, freeVec, issueVec, insVec;

  always_comb begin
    readyVec = slotValid & aAvail & bAvail;
    issueVec = readyVec & (~readyVec + LSB_ONE);
    freeVec  = ~slotValid;
    insReady = |freeVec;
    insVec   = insValid ? (freeVec & (~freeVec + LSB_ONE)) : '0;

    strb           = '0;
    strb.insWr     = insVec;
    strb.issue     = issueVec;
    strb.issueFire = |issueVec;
    strb.insCapA   = bcValid && !insAAvail && (insATag == bcTag);
    strb.insCapB   = bcValid && !insBAvail && (insBTag == bcTag);
    for (int i = 0; i < RS_COUNT; i++) begin
      strb.capA[i] = bcValid && slotValid[i] && !aAvail[i] && (aTag[i] == bcTag);
      strb.capB[i] = bcValid && slotValid[i] && !bAvail[i] && (bTag[i] == bcTag);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotValid <= '0;
      aAvail    <= '0;
      bAvail    <= '0;
      for (int i = 0; i < RS_COUNT; i++) begin
        aTag[i] <= '0;
        bTag[i] <= '0;
      end
    end else begin
      for (int i = 0; i < RS_COUNT; i++) begin
        if (insVec[i]) begin
          slotValid[i] <= 1'b1;
          aAvail[i]    <= insAAvail | strb.insCapA;
          bAvail[i]    <= insBAvail | strb.insCapB;
          aTag[i]      <= insATag;
          bTag[i]      <= insBTag;
        end else if (issueVec[i]) begin
          slotValid[i] <= 1'b0;
        end else begin
          if (strb.capA[i]) aAvail[i] <= 1'b1;
          if (strb.capB[i]) bAvail[i] <= 1'b1;
        end
      end
    end
  end

  AST_ONE_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.issue)); // R3

  AST_REFUSED_INSERT: assert property (@(posedge clk) disable iff (!rstN)
    insValid && !insReady |=> slotValid == ($past(slotValid) & ~$past(strb.issue))); // R1

  for (genvar g = 0; g < RS_COUNT; g++) begin : g_slotChk
    AST_FREED_ON_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
      strb.issue[g] |=> !slotValid[g]); // R7

    AST_A_STAYS_WAITING: assert property (@(posedge clk) disable iff (!rstN)
      slotValid[g] && !aAvail[g] && !(bcValid && bcTag == aTag[g]) |=> !aAvail[g]); // R2

    AST_B_STAYS_WAITING: assert property (@(posedge clk) disable iff (!rstN)
      slotValid[g] && !bAvail[g] && !(bcValid && bcTag == bTag[g]) |=> !bAvail[g]); // R2
  end
endmodule

// File: rtl/rsv_data.sv
`timescale 1ns/1ps
module rsv_data import rsv_pkg::*; (
  input  logic              clk,
  input  logic              rstN,
  input  rsStrobe_t         strb,
  input  logic [1:0]        insOp,
  input  logic [TAG_W-1:0]  insDst,
  input  logic [DATA_W-1:0] insAData,
  input  logic [DATA_W-1:0] insBData,
  output logic              bcValid,
  output logic [TAG_W-1:0]  bcTag,
  output logic [DATA_W-1:0] bcData
);
  aluOp_e            opReg  [RS_COUNT];
  logic [TAG_W-1:0]  dstReg [RS_COUNT];
  logic [DATA_W-1:0] aData  [RS_COUNT];
  logic [DATA_W-1:0] bData  [RS_COUNT];

  aluOp_e            selOp;
  logic [TAG_W-1:0]  selDst;
  logic [DATA_W-1:0] selA, selB, aluRes;

  always_comb begin
    selOp  = OP_ADD;
    selDst = '0;
    selA   = '0;
    selB   = '0;
    for (int i = 0; i < RS_COUNT; i++) begin
      if (strb.issue[i]) begin
        selOp  = opReg[i];
        selDst = dstReg[i];
        selA   = aData[i];
        selB   = bData[i];
      end
    end
    case (selOp)
      OP_ADD:  aluRes = selA + selB;
      OP_SUB:  aluRes = selA - selB;
      OP_MUL:  aluRes = selA * selB;
      default: aluRes = selA ^ selB;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bcValid <= 1'b0;
      bcTag   <= '0;
      bcData  <= '0;
      for (int i = 0; i < RS_COUNT; i++) begin
        opReg[i]  <= OP_ADD;
        dstReg[i] <= '0;
        aData[i]  <= '0;
        bData[i]  <= '0;
      end
    end else begin
      bcValid <= strb.issueFire;
      bcTag   <= selDst;
      bcData  <= aluRes;
      for (int i = 0; i < RS_COUNT; i++) begin
        if (strb.insWr[i]) begin
          opReg[i]  <= aluOp_e'(insOp);
          dstReg[i] <= insDst;
          aData[i]  <= strb.insCapA ? bcData : insAData;
          bData[i]  <= strb.insCapB ? bcData : insBData;
        end else begin
          if (strb.capA[i]) aData[i] <= bcData;
          if (strb.capB[i]) bData[i] <= bcData;
        end
      end
    end
  end

  AST_BC_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
    strb.issueFire |=> bcValid); // R4

  AST_NO_BC_WITHOUT_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.issueFire |=> !bcValid); // R4
endmodule

// File: rtl/rsv_wakeup_bank.sv
`timescale 1ns/1ps
module rsv_wakeup_bank import rsv_pkg::*; (
  input  logic              clk,
  input  logic              rstN,
  input  logic              insValid,
  output logic              insReady,
  input  logic [1:0]        insOp,
  input  logic [TAG_W-1:0]  insDst,
  input  logic              insAAvail,
  input  logic [TAG_W-1:0]  insATag,
  input  logic [DATA_W-1:0] insAData,
  input  logic              insBAvail,
  input  logic [TAG_W-1:0]  insBTag,
  input  logic [DATA_W-1:0] insBData,
  output logic              bcValid,
  output logic [TAG_W-1:0]  bcTag,
  output logic [DATA_W-1:0] bcData
);
  rsStrobe_t strb;

  rsv_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .insValid(insValid), .insReady(insReady),
    .insAAvail(insAAvail), .insATag(insATag),
    .insBAvail(insBAvail), .insBTag(insBTag),
    .bcValid(bcValid), .bcTag(bcTag),
    .strb(strb)
  );

  rsv_data data_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .insOp(insOp), .insDst(insDst),
    .insAData(insAData), .insBData(insBData),
    .bcValid(bcValid), .bcTag(bcTag), .bcData(bcData)
  );
endmodule

// File: tb/rsv_wakeup_bank_tb.sv
`timescale 1ns/1ps
module rsv_wakeup_bank_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        insValid = 1'b0;
  logic        insReady;
  logic [1:0]  insOp = '0;
  logic [5:0]  insDst = '0;
  logic        insAAvail = 1'b0;
  logic [5:0]  insATag = '0;
  logic [31:0] insAData = '0;
  logic        insBAvail = 1'b0;
  logic [5:0]  insBTag = '0;
  logic [31:0] insBData = '0;
  logic        bcValid;
  logic [5:0]  bcTag;
  logic [31:0] bcData;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  always #5 clk = ~clk;

  rsv_wakeup_bank dut_i (
    .clk(clk), .rstN(rstN),
    .insValid(insValid), .insReady(insReady),
    .insOp(insOp), .insDst(insDst),
    .insAAvail(insAAvail), .insATag(insATag), .insAData(insAData),
    .insBAvail(insBAvail), .insBTag(insBTag), .insBData(insBData),
    .bcValid(bcValid), .bcTag(bcTag), .bcData(bcData)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic [5:0]  tag;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] res;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'd0, 6'd21, 32'h0001_aa00, 32'h0000_0034, 32'h0001_aa34},
    '{2'd1, 6'd22, 32'h0000_0005, 32'h0000_0007, 32'hffff_fffe},
    '{2'd2, 6'd23, 32'h0001_0000, 32'h0001_0003, 32'h0003_0000},
    '{2'd3, 6'd24, 32'hf0f0_f0f0, 32'h0ff0_0ff0, 32'hff00_ff00},
    '{2'd0, 6'd25, 32'hffff_ffff, 32'h0000_0002, 32'h0000_0001},
    '{2'd2, 6'd26, 32'h1234_5678, 32'h0000_0010, 32'h2345_6780}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clearIns();
    insValid = 1'b0;
  endtask

  task automatic drive(input logic [1:0] op, input logic [5:0] dst,
                       input logic aAv, input logic [5:0] aT, input logic [31:0] aD,
                       input logic bAv, input logic [5:0] bT, input logic [31:0] bD);
    insValid = 1'b1; insOp = op; insDst = dst;
    insAAvail = aAv; insATag = aT; insAData = aD;
    insBAvail = bAv; insBTag = bT; insBData = bD;
  endtask

  task automatic doReset();
    clearIns();
    rstN = 1'b0;
    tick();
    tick();
    rstN = 1'b1;
    tick();
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    doReset();
    chk("R8 insReady after reset", {31'd0, insReady}, 32'd1);
    chk("R8 bcValid after reset", {31'd0, bcValid}, 32'd0);

    // R4: table of ALU operations, each with both operands present
    for (int v = 0; v < 6; v++) begin
      drive(VECS[v].op, VECS[v].tag, 1'b1, 6'd0, VECS[v].a, 1'b1, 6'd0, VECS[v].b);
      tick();
      clearIns();
      tick();
      chk("R4 bcValid", {31'd0, bcValid}, 32'd1);
      chk("R4 bcTag", {26'd0, bcTag}, {26'd0, VECS[v].tag});
      chk("R4 bcData", bcData, VECS[v].res);
    end

    // R5/R3: two waiters woken by one broadcast, lowest slot goes first
    doReset();
    drive(2'd1, 6'd30, 1'b0, 6'd21, 32'd0, 1'b1, 6'd0, 32'd4);
    tick();
    drive(2'd2, 6'd31, 1'b1, 6'd0, 32'd2, 1'b0, 6'd21, 32'd0);
    tick();
    chk("R2 waiters do not issue", {31'd0, bcValid}, 32'd0);
    drive(2'd0, 6'd21, 1'b1, 6'd0, 32'h1aa00, 1'b1, 6'd0, 32'h34);
    tick();
    clearIns();
    chk("R2 no broadcast before producer", {31'd0, bcValid}, 32'd0);
    tick();
    chk("R5 producer tag", {26'd0, bcTag}, 32'd21);
    chk("R5 producer data", bcData, 32'h1aa34);
    tick();
    chk("R5 gap after wake", {31'd0, bcValid}, 32'd0);
    tick();
    chk("R3 first woken is slot 0 tag", {26'd0, bcTag}, 32'd30);
    chk("R5 slot 0 result", bcData, 32'h1aa30);
    tick();
    chk("R3 second woken tag", {26'd0, bcTag}, 32'd31);
    chk("R5 slot 1 result", bcData, 32'h35468);

    // R6: insert during the matching broadcast; a late waiter never wakes
    doReset();
    drive(2'd0, 6'd40, 1'b1, 6'd0, 32'd1, 1'b1, 6'd0, 32'd2);
    tick();
    clearIns();
    tick();
    chk("R6 producer tag", {26'd0, bcTag}, 32'd40);
    drive(2'd3, 6'd41, 1'b0, 6'd40, 32'd0, 1'b1, 6'd0, 32'd5);
    tick();
    chk("R6 no broadcast while consumer enters", {31'd0, bcValid}, 32'd0);
    drive(2'd0, 6'd42, 1'b0, 6'd40, 32'd0, 1'b1, 6'd0, 32'd0);
    tick();
    clearIns();
    chk("R6 consumer tag", {26'd0, bcTag}, 32'd41);
    chk("R6 consumer data", bcData, 32'd6);
    begin
      int seen = 0;
      for (int k = 0; k < 6; k++) begin
        tick();
        if (bcValid) seen++;
      end
      chk("R2 late waiter never issues", seen, 32'd0);
    end

    // R1: fill all stations with waiters on an absent tag, then offer more
    doReset();
    for (int k = 0; k < 4; k++) begin
      drive(2'd0, 6'(k + 1), 1'b0, 6'd50, 32'd0, 1'b1, 6'd0, 32'd1);
      tick();
    end
    clearIns();
    chk("R1 insReady low when full", {31'd0, insReady}, 32'd0);
    drive(2'd0, 6'd9, 1'b1, 6'd0, 32'd3, 1'b1, 6'd0, 32'd3);
    begin
      int seen = 0;
      for (int k = 0; k < 3; k++) begin
        tick();
        if (bcValid) seen++;
      end
      clearIns();
      for (int k = 0; k < 4; k++) begin
        tick();
        if (bcValid) seen++;
      end
      chk("R1 refused insert never broadcasts", seen, 32'd0);
    end
    chk("R1 still full", {31'd0, insReady}, 32'd0);
    doReset();
    chk("R8 reset frees stuck stations", {31'd0, insReady}, 32'd1);

    // R7: station is free again in its broadcast cycle
    for (int k = 0; k < 3; k++) begin
      drive(2'd0, 6'(k + 11), 1'b0, 6'd60, 32'd0, 1'b1, 6'd0, 32'd1);
      tick();
    end
    drive(2'd1, 6'd7, 1'b1, 6'd0, 32'd10, 1'b1, 6'd0, 32'd3);
    tick();
    clearIns();
    chk("R7 full while issuing", {31'd0, insReady}, 32'd0);
    tick();
    chk("R7 broadcast tag", {26'd0, bcTag}, 32'd7);
    chk("R7 broadcast data", bcData, 32'd7);
    chk("R7 insReady in broadcast cycle", {31'd0, insReady}, 32'd1);
    drive(2'd3, 6'd8, 1'b1, 6'd0, 32'ha, 1'b1, 6'd0, 32'hc);
    tick();
    clearIns();
    tick();
    chk("R7 reused station tag", {26'd0, bcTag}, 32'd8);
    chk("R7 reused station data", bcData, 32'd6);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule